// File: doc/BRIEF.md
# Slotted Expansion Bus Decoder

This block sits on the external bus of an 8-bit processor and turns a 128-byte I/O window into eight card slots. The seven low address bits select a location: the upper three pick a slot and raise that slot's select line, the lower four pick one of sixteen register strobes that are shared by every slot. A card decides that it is being addressed by combining its own slot select, one shared strobe and either the true or the inverted read/write line. Because every card sees the same relative register numbers, a card works in whichever slot it is plugged into.

All bus inputs are sampled by a fast system clock through two-stage synchronizers. Decoding happens only while the active-low window enable is low and the second-phase qualifier is high. The qualifier marks the half of the bus cycle in which data is valid, so a write can never be seen before its data is on the bus. The block also holds a model of the cards' write latches, one byte per slot and register. A latch loads the bus byte on the rising edge of its write hit, so a bench can confirm where each write landed.

Top module: `slot_bus_decoder`

## Requirements
- R1: `slot_sel[k]` is high exactly when the window is enabled (`win_n` low), `bus_ph2` is high and address bits 6..4 equal k. All other slot selects are low.
- R2: `reg_stb[j]` is high exactly when the window is enabled, `bus_ph2` is high and address bits 3..0 equal j. The same strobe is shared by all slots.
- R3: While `win_n` is high, every slot select and every register strobe is low, whatever the address.
- R4: While `bus_ph2` is low, every slot select and every register strobe is low, even with the window enabled.
- R5: At no time is more than one slot select high, and at no time is more than one register strobe high.
- R6: `rw_true` follows `bus_rw`, where 1 means read and 0 means write. `rw_inv` is always its complement.
- R7: Every output follows its bus input with a latency of exactly two system clock edges. After the first edge the output still shows the old value.
- R8: A write hit for slot s and register r is slot select, strobe and `rw_inv` all high. On its rising edge, the byte on `bus_data` is stored into `card_regs[(s*16+r)*8 +: 8]`.
- R9: A read access, with `bus_rw` high, never changes any latch, even while data is on the bus.
- R10: A latch keeps its value until the next write hit to the same slot and register. Writes to any other location leave it unchanged.
- R11: Synchronous reset clears all latches to zero and drives all selects and strobes low.
- R12: A write hit held high loads only once. If the bus data changes while the hit stays high, the latch keeps the byte it captured on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Low address bits of the window |
| win_n | input | 1 | Active-low window enable |
| bus_rw | input | 1 | Read/write line, 1 = read |
| bus_ph2 | input | 1 | Second-phase qualifier, high while data is valid |
| bus_data | input | 8 | Processor data bus |
| slot_sel | output | 8 | Active-high per-slot select |
| reg_stb | output | 16 | Active-high register strobes, shared by all slots |
| rw_true | output | 1 | Read/write distributed in true form |
| rw_inv | output | 1 | Read/write distributed in inverted form |
| card_regs | output | 1024 | Card write latches, byte (s*16+r) for slot s, register r |

## Verification
The bench sweeps all 128 addresses and checks both decode dimensions. A swapped or shifted address field would light the wrong slot or strobe, and a missing gate would let strobes through while the window or the phase qualifier is off. It writes distinct bytes to corner locations and to neighbouring ones. A wrong latch index or a loose hit equation would then show up as a corrupted neighbour, and a read that loads shows up as a changed byte after a read pass with data on the bus. It changes the data while a write hit is held, which catches a latch that is level-loaded instead of edge-loaded. It also samples one edge early to expose a synchronizer with the wrong depth.

// File: rtl/slot_bus_pkg.sv
package slot_bus_pkg;

    localparam int SLOT_BITS = 3;
    localparam int REG_BITS  = 4;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = SLOT_BITS + REG_BITS;
    localparam int N_SLOTS   = 1 << SLOT_BITS;
    localparam int N_REGS    = 1 << REG_BITS;

    typedef struct packed {
        logic              win_n;
        logic              rw;
        logic              ph2;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } bus_sample_t;

    localparam bus_sample_t BUS_IDLE = '{
        win_n: 1'b1, rw: 1'b1, ph2: 1'b0, data: '0, addr: '0
    };

    function automatic logic [REG_BITS-1:0] reg_field(input logic [ADDR_W-1:0] a);
        return a[REG_BITS-1:0];
    endfunction

    function automatic logic [SLOT_BITS-1:0] slot_field(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:REG_BITS];
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/onehot_decoder.sv
module onehot_decoder #(
    parameter int IN_W  = 3,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  sel,
    input  logic             en,
    output logic [OUT_N-1:0] dec
);
    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign dec[k] = en && (sel == IN_W'(k));
    end
endmodule

// File: rtl/card_latch.sv
module card_latch #(
    parameter int  N_REGS = 16,
    parameter int  DATA_W = 8,
    localparam int FLAT_W = N_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_en,
    input  logic [N_REGS-1:0] reg_stb,
    input  logic              rw_inv,
    input  logic [DATA_W-1:0] data,
    output logic [FLAT_W-1:0] regs_q
);
    logic [N_REGS-1:0] hit, hit_q, load;

    assign hit  = {N_REGS{slot_en & rw_inv}} & reg_stb;
    assign load = hit & ~hit_q;

    always_ff @(posedge clk) begin
        if (rst) hit_q <= '0;
        else     hit_q <= hit;
    end

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)          regs_q[r*DATA_W +: DATA_W] <= '0;
            else if (load[r]) regs_q[r*DATA_W +: DATA_W] <= data;
        end

        assert_load_R8: assert property (@(posedge clk) disable iff (rst)
            load[r] |=> regs_q[r*DATA_W +: DATA_W] == $past(data));

        assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
            !load[r] |=> $stable(regs_q[r*DATA_W +: DATA_W]));

        assert_once_R12: assert property (@(posedge clk) disable iff (rst)
            (hit[r] && hit_q[r]) |=> $stable(regs_q[r*DATA_W +: DATA_W]));
    end

    assert_read_R9: assert property (@(posedge clk) disable iff (rst)
        !rw_inv |=> $stable(regs_q));
endmodule

// File: rtl/slot_bus_decoder.sv
module slot_bus_decoder
    import slot_bus_pkg::*;
#(
    localparam int FLAT_W = N_SLOTS * N_REGS * DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               win_n,
    input  logic               bus_rw,
    input  logic               bus_ph2,
    input  logic [DATA_W-1:0]  bus_data,
    output logic [N_SLOTS-1:0] slot_sel,
    output logic [N_REGS-1:0]  reg_stb,
    output logic               rw_true,
    output logic               rw_inv,
    output logic [FLAT_W-1:0]  card_regs
);
    localparam int CARD_W = N_REGS * DATA_W;

    bus_sample_t raw, synced;
    logic        decode_en;

    assign raw = '{win_n: win_n, rw: bus_rw, ph2: bus_ph2, data: bus_data, addr: bus_addr};

    bus_sync #(.W($bits(bus_sample_t)), .RST_VAL(BUS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign decode_en = ~synced.win_n & synced.ph2;

    onehot_decoder #(.IN_W(SLOT_BITS)) u_slot_dec (
        .sel (slot_field(synced.addr)),
        .en  (decode_en),
        .dec (slot_sel)
    );

    onehot_decoder #(.IN_W(REG_BITS)) u_reg_dec (
        .sel (reg_field(synced.addr)),
        .en  (decode_en),
        .dec (reg_stb)
    );

    assign rw_true = synced.rw;
    assign rw_inv  = ~synced.rw;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_card
        card_latch #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_card (
            .clk     (clk),
            .rst     (rst),
            .slot_en (slot_sel[s]),
            .reg_stb (reg_stb),
            .rw_inv  (rw_inv),
            .data    (synced.data),
            .regs_q  (card_regs[s*CARD_W +: CARD_W])
        );
    end

    // Cycles since reset, saturating; lets pin-to-pin checks skip the pipeline fill.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_sel) && $onehot0(reg_stb));

    assert_window_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2 && $past(win_n, 2)) |-> (slot_sel == '0 && reg_stb == '0));

    assert_phase_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2 && !$past(bus_ph2, 2)) |-> (slot_sel == '0 && reg_stb == '0));

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        since_rst == 2 |-> rw_true == $past(bus_rw, 2));

    assert_paired_R1: assert property (@(posedge clk) disable iff (rst)
        (slot_sel != '0) == (reg_stb != '0));
endmodule

// File: tb/slot_bus_decoder_tb.sv
`timescale 1ns/1ps
module slot_bus_decoder_tb;
    import slot_bus_pkg::*;

    localparam int FLAT_W = N_SLOTS * N_REGS * DATA_W;
    localparam int N_LOC  = N_SLOTS * N_REGS;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               win_n = 1'b1;
    logic               bus_rw = 1'b1;
    logic               bus_ph2 = 1'b0;
    logic [DATA_W-1:0]  bus_data = '0;
    logic [N_SLOTS-1:0] slot_sel;
    logic [N_REGS-1:0]  reg_stb;
    logic               rw_true, rw_inv;
    logic [FLAT_W-1:0]  card_regs;

    slot_bus_decoder u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .win_n(win_n), .bus_rw(bus_rw),
        .bus_ph2(bus_ph2), .bus_data(bus_data), .slot_sel(slot_sel), .reg_stb(reg_stb),
        .rw_true(rw_true), .rw_inv(rw_inv), .card_regs(card_regs)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          kind;   // 0 slot_sel, 1 reg_stb, 2 latch byte, 3 rw pair
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t             sb[$];
    logic [DATA_W-1:0] model [N_LOC];
    int                n_checks = 0;
    int                n_fail   = 0;
    bit                done     = 0;

    // Monitor: pops expected items and compares them with the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = 32'(slot_sel);
                1:       act = 32'(reg_stb);
                2:       act = 32'(card_regs[it.idx*DATA_W +: DATA_W]);
                default: act = {30'd0, rw_true, rw_inv};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                         it.req, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic expect_item(int kind, int idx, logic [31:0] exp, string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(logic [ADDR_W-1:0] a, logic wn, logic rw, logic ph, logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; win_n = wn; bus_rw = rw; bus_ph2 = ph; bus_data = d;
    endtask

    task automatic go_idle();
        drive(bus_addr, 1'b1, 1'b1, 1'b0, bus_data);
        settle(4);
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        drive(a, 1'b0, 1'b0, 1'b0, d);
        settle(1);
        drive(a, 1'b0, 1'b0, 1'b1, d);
        settle(4);
        model[a] = d;
        go_idle();
    endtask

    task automatic check_all_latches(string req);
        for (int i = 0; i < N_LOC; i++) expect_item(2, i, 32'(model[i]), req);
        settle(1);
    endtask

    initial begin
        for (int i = 0; i < N_LOC; i++) model[i] = '0;
        settle(3);
        @(negedge clk); rst = 1'b0;
        settle(1);

        // R11: reset state
        expect_item(0, 0, 32'd0, "R11");
        expect_item(1, 0, 32'd0, "R11");
        expect_item(2, 0, 32'd0, "R11");
        expect_item(2, N_LOC-1, 32'd0, "R11");
        settle(1);

        // R1 R2 R5 R6: full address sweep with reads
        for (int a = 0; a < N_LOC; a++) begin
            drive(ADDR_W'(a), 1'b0, 1'b1, 1'b1, 8'hA5);
            settle(2);
            expect_item(0, a, 32'(1) << (a >> REG_BITS), "R1");
            expect_item(1, a, 32'(1) << (a % N_REGS), "R2");
            expect_item(3, a, 32'd2, "R6");
            settle(1);
        end

        // R3: window disabled, phase high
        for (int a = 0; a < N_LOC; a += 9) begin
            drive(ADDR_W'(a), 1'b1, 1'b1, 1'b1, 8'h00);
            settle(2);
            expect_item(0, a, 32'd0, "R3");
            expect_item(1, a, 32'd0, "R3");
            settle(1);
        end

        // R4: phase low, window enabled
        for (int a = 5; a < N_LOC; a += 13) begin
            drive(ADDR_W'(a), 1'b0, 1'b0, 1'b0, 8'h3C);
            settle(2);
            expect_item(0, a, 32'd0, "R4");
            expect_item(1, a, 32'd0, "R4");
            expect_item(3, a, 32'd1, "R6");
            settle(1);
        end
        go_idle();
        check_all_latches("R9");

        // R7: exactly two edges of latency
        drive(7'h23, 1'b0, 1'b1, 1'b1, 8'h00);
        settle(1);
        expect_item(0, 1, 32'd0, "R7");
        settle(1);
        expect_item(0, 2, 32'h04, "R7");
        expect_item(1, 2, 32'h08, "R7");
        settle(1);
        go_idle();

        // R8 R10: writes to corners and neighbours
        bus_write(7'h00, 8'h11);
        bus_write(7'h7F, 8'hEE);
        bus_write(7'h10, 8'h5A);
        bus_write(7'h0F, 8'hC3);
        bus_write(7'h4B, 8'h96);
        check_all_latches("R8");
        bus_write(7'h10, 8'h77);
        check_all_latches("R10");

        // R9: reads with data on the bus change nothing
        for (int a = 0; a < N_LOC; a += 7) begin
            drive(ADDR_W'(a), 1'b0, 1'b1, 1'b1, 8'hFF);
            settle(3);
        end
        go_idle();
        check_all_latches("R9");

        // R12: data changes while the write hit is held
        drive(7'h35, 1'b0, 1'b0, 1'b0, 8'h42);
        settle(1);
        drive(7'h35, 1'b0, 1'b0, 1'b1, 8'h42);
        settle(4);
        drive(7'h35, 1'b0, 1'b0, 1'b1, 8'hBD);
        settle(4);
        model[7'h35] = 8'h42;
        expect_item(2, 7'h35, 32'h42, "R12");
        settle(1);
        go_idle();
        check_all_latches("R12");

        // R11: reset clears latches
        @(negedge clk); rst = 1'b1;
        settle(2);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < N_LOC; i++) model[i] = '0;
        settle(1);
        check_all_latches("R11");

        settle(2);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule